// File: doc/BRIEF.md
# Pixel Hit Matrix Readout Sequencer

This block holds an 8 by 8 array of one-bit pixel hit latches and the sequencer that runs a frame over them. Each pixel input is already a binary result: a single shared threshold has been applied upstream. A frame starts on a `start` request. The array is cleared in one cycle. Hits are then gathered during an acquisition window whose length is set in clock cycles. After the window closes, the columns are presented one per clock as row words, column 0 first.

Once a latch is set it stays set until the clear phase of the next frame. A global `trigger` output is the OR of all latches. The readout takes eight cycles per frame, which is 240 ns at a 30 ns clock.

Top module: `pixel_frame_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, `col_valid` and `trigger` are 0.
- R2: A `start` sampled high while idle begins a frame. The frame has one clear cycle, then a gate window of `gate_len` cycles, then eight readout cycles, then a return to idle.
- R3: The clear cycle zeroes every latch, so `trigger` is 0 in the first gate cycle.
- R4: A `hit_in` bit that is high at any clock edge inside the gate window sets its latch. The latch stays set even if the input drops.
- R5: `hit_in` has no effect at edges outside the gate window, that is in idle, clear or readout.
- R6: `trigger` equals the OR of all 64 latches. It rises in the cycle after the first captured hit.
- R7: Readout drives `col_valid` high for eight consecutive cycles, with `col_idx` counting 0 to 7. Pixel (row r, column c) is input bit `hit_in[c*8+r]` and is shown as bit r of `col_data` when `col_idx` = c.
- R8: Latches do not change during readout or in idle. They keep their values until the next clear cycle.
- R9: A `start` that arrives while a frame is in progress is ignored.
- R10: A `gate_len` of 0 gives a gate window of one cycle, the same as a `gate_len` of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, sampled in idle |
| gate_len | input | 8 | Gate window length in cycles |
| hit_in | input | 64 | Per-pixel discriminator results, column-major |
| col_data | output | 8 | Row word of the column being read |
| col_idx | output | 3 | Index of the column being read |
| col_valid | output | 1 | Column word valid |
| trigger | output | 1 | OR of all pixel latches |

## Verification
Each result has a fixed delay after its stimulus:
- The clear cycle follows the `start` edge by one cycle.
- The gate follows one cycle after that.
- A captured hit shows on `trigger` one cycle after its edge.
- The first column word appears in the cycle after the last gate edge.

A behavioural reference in the bench advances on the same rising edges as the design. Every output is compared on the falling edge, so each expected value is sampled in the cycle it is due. Pixel patterns are placed in the idle, clear, gate and readout phases, and the bench checks whether their effects reach the ports in that cycle.

// File: rtl/pixel_frame_reader.sv
module pixel_frame_reader #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int GATE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [GATE_W-1:0]        gate_len,
  input  logic [ROWS*COLS-1:0]     hit_in,
  output logic [ROWS-1:0]          col_data,
  output logic [$clog2(COLS)-1:0]  col_idx,
  output logic                     col_valid,
  output logic                     trigger
);
  localparam int NPIX = ROWS * COLS;
  localparam int CW   = $clog2(COLS);
  localparam logic [CW-1:0] LAST = CW'(COLS - 1);

  typedef enum logic [1:0] {S_IDLE, S_CLR, S_GATE, S_READ} st_t;

  st_t              st;
  logic [GATE_W-1:0] cnt;
  logic [CW-1:0]    col;
  logic [NPIX-1:0]  lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      col <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_CLR;
        S_CLR: begin
          st  <= S_GATE;
          cnt <= gate_len;
        end
        S_GATE: begin
          if (cnt <= GATE_W'(1)) begin
            st  <= S_READ;
            col <= '0;
          end else begin
            cnt <= cnt - GATE_W'(1);
          end
        end
        S_READ: begin
          if (col == LAST) st <= S_IDLE;
          else col <= col + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            lat <= '0;
    else if (st == S_CLR)  lat <= '0;
    else if (st == S_GATE) lat <= lat | hit_in;
  end

  assign col_valid = (st == S_READ);
  assign col_idx   = col;
  assign col_data  = lat[int'(col)*ROWS +: ROWS];
  assign trigger   = |lat;

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLR) |=> !trigger);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GATE) |=> ((lat & $past(lat)) == $past(lat)));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ || st == S_IDLE) |=> $stable(lat));

  p_col_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_idx != LAST) |=> (col_valid && col_idx == $past(col_idx) + CW'(1)));

  p_frame_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_idx == LAST) |=> !col_valid);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && start && col_idx != LAST) |=> col_valid);
endmodule

// File: tb/sim_pixel_frame_reader.sv
module sim_pixel_frame_reader;
  localparam int CLK_NS = 30;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [7:0]  gate_len = 8'd4;
  logic [63:0] hit_in = '0;
  logic [7:0]  col_data;
  logic [2:0]  col_idx;
  logic        col_valid;
  logic        trigger;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string tag = "R2";

  pixel_frame_reader u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_len(gate_len),
    .hit_in(hit_in), .col_data(col_data), .col_idx(col_idx),
    .col_valid(col_valid), .trigger(trigger)
  );

  always #(CLK_NS/2) clk = ~clk;

  int          m_ph = 0;
  int          m_cnt = 0;
  int          m_col = 0;
  bit [63:0]   m_lat = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_lat = '0; m_col = 0;
    end else begin
      case (m_ph)
        0: if (start) m_ph = 1;
        1: begin m_lat = '0; m_ph = 2; m_cnt = (gate_len == 0) ? 1 : int'(gate_len); end
        2: begin
          m_lat = m_lat | hit_in;
          if (m_cnt == 1) begin m_ph = 3; m_col = 0; end
          else m_cnt = m_cnt - 1;
        end
        default: if (m_col == 7) m_ph = 0; else m_col = m_col + 1;
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({tag, " R2 valid"}, int'(col_valid), int'(m_ph == 3));
      chk({tag, " R6 trigger"}, int'(trigger), int'(|m_lat));
      if (m_ph == 3) begin
        chk({tag, " R7 col_idx"}, int'(col_idx), m_col);
        chk({tag, " R7 col_data"}, int'(col_data), int'(m_lat[m_col*8 +: 8]));
      end
    end
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic bit [63:0] px(int r, int c);
    px = 64'd1 << (c*8 + r);
  endfunction

  task automatic frame(input int glen, input bit [63:0] p1, input bit [63:0] p2,
                       input bit [63:0] outside, input bit busy_start);
    @(negedge clk);
    gate_len = 8'(glen); start = 1; hit_in = outside;
    @(negedge clk);
    start = 0; hit_in = outside;
    @(negedge clk);
    chk("R3 trigger low first gate cycle", int'(trigger), 0);
    hit_in = p1;
    @(negedge clk);
    hit_in = p2;
    @(negedge clk);
    hit_in = '0;
    while (m_ph != 3) @(negedge clk);
    hit_in = outside;
    start = busy_start;
    while (m_ph != 0) @(negedge clk);
    start = 0;
    hit_in = outside;
    repeat (3) @(negedge clk);
    hit_in = '0;
  endtask

  initial begin
    #1;
    chk("R1 valid in reset", int'(col_valid), 0);
    chk("R1 trigger in reset", int'(trigger), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", int'(col_valid), 0);
    chk("R1 trigger after reset", int'(trigger), 0);

    tag = "R4";
    frame(4, px(0,0) | px(7,7), px(3,5) | px(6,1), '0, 0);

    tag = "R5";
    frame(3, px(2,2), '0, px(1,4) | px(5,6) | px(0,7), 0);

    tag = "R9";
    frame(2, px(4,3), px(4,0), '0, 1);
    repeat (12) @(negedge clk);
    chk("R9 start during readout ignored", int'(col_valid), 0);

    tag = "R10";
    frame(0, px(7,0), px(6,6), '0, 0);
    frame(1, px(1,1), px(2,3), '0, 0);

    tag = "R8";
    frame(5, {64{1'b1}}, '0, '0, 0);
    chk("R8 trigger held in idle", int'(trigger), 1);

    tag = "R2";
    frame(6, '0, '0, px(4,4), 0);
    chk("R5 no hits inside gate, trigger low", int'(trigger), 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule